// File: doc/BRIEF.md
# Isochronous IN Endpoint Ping-Pong Buffer Manager

This block serves one isochronous IN endpoint from two packet buffers, called X and Y, that share a small byte memory. A producer (a DMA engine or firmware) fills one buffer, then writes that buffer's count byte. Bit 7 of the count byte is the NACK flag and bits 6:0 hold the sample count. Writing the count byte with bit 7 at 0 hands the buffer to the sender. When the USB serial engine presents an IN token, the manager looks at the active buffer. If its NACK flag is clear, the manager announces a packet and streams the bytes out. If the flag is set, it announces a zero-length packet. In both cases the buffer is then marked NACK and the other buffer becomes active.

Isochronous traffic never stalls here and raises no interrupt: a buffer that was not refilled in time simply yields a null packet. Firmware programs the buffer size, the two base addresses and the bytes-per-sample code through a small register port. The same port shows a sticky overflow flag, which is raised when the producer writes past the end of a buffer.

Top module: `iso_in_dbuf`

## Requirements
- R1: After reset, hs_valid, tx_valid, busy and act_buf are 0. The control register (address 0) reads 0x00. Both count bytes (address 4 for X, address 5 for Y) read 0x80, which means NACK is set with zero samples.
- R2: An IN token sampled while the endpoint is on, idle, and the active buffer's NACK (count bit 7) is clear gives hs_valid for exactly one cycle, starting the cycle after the token. In that cycle hs_null is 0 and hs_len is the packet length.
- R3: The packet bytes appear on tx_data from memory[(base + i) mod memory size], for i = 0 to hs_len-1, starting in the same cycle as hs_valid. tx_last marks the final byte. While tx_ready is low, the byte is held.
- R4: When a transaction completes (last byte accepted, or null packet sent), bit 7 of that buffer's count byte reads 1.
- R5: If the active buffer's NACK is set at the token, hs_valid comes with hs_null=1 and hs_len=0, and no byte is sent.
- R6: act_buf (0=X, 1=Y) toggles after every completed transaction, whether data or null.
- R7: Writing the control register so that the enable bit (bit 0) and the isochronous bit (bit 1) are both 1, while the endpoint was not on, sets act_buf to X and sets NACK on both count bytes.
- R8: While enable or isochronous is 0, tokens are ignored. hs_valid stays 0 and act_buf is unchanged.
- R9: A producer data write whose offset is not below the buffer size (address 1) is dropped and sets the overflow flag (control bit 7). The flag stays set until a control write with bit 7 at 0 clears it. Writes within the size do not set it.
- R10: hs_len = min(samples × (code+1), size). Here code is the bytes-per-sample field in control bits 3:2.
- R11: A token that arrives while a transaction is in progress (busy=1) is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register address: 0 control, 1 size, 2 X base, 3 Y base, 4 X count, 5 Y count |
| cfg_wdata | input | 8 | Register write data |
| cfg_rdata | output | 8 | Register read data (combinational) |
| prod_we | input | 1 | Producer write strobe |
| prod_cnt | input | 1 | 1: write count byte, 0: write data byte |
| prod_buf | input | 1 | Target buffer, 0=X, 1=Y |
| prod_off | input | 8 | Byte offset inside the buffer |
| prod_wdata | input | 8 | Producer write data |
| tok_in | input | 1 | IN token pulse from the serial engine |
| hs_valid | output | 1 | One-cycle packet announcement |
| hs_null | output | 1 | Announced packet is zero-length (stale buffer) |
| hs_len | output | 8 | Announced byte count |
| tx_valid | output | 1 | Data byte valid |
| tx_ready | input | 1 | Serial engine accepts the byte |
| tx_data | output | 8 | Data byte |
| tx_last | output | 1 | Final byte of the packet |
| act_buf | output | 1 | Active buffer, 0=X, 1=Y |
| busy | output | 1 | Transaction in progress |

## Verification
The token is registered once, so hs_valid, hs_len, hs_null and the first byte are due one cycle after the token edge. Each further byte is due one cycle after the previous byte was accepted. For a data packet, the NACK set and the act_buf toggle are due on the edge that accepts the last byte. For a null packet, they are due one cycle after the announcement. Register writes and producer writes show on cfg_rdata in the cycle after their edge. The bench drives every input on the falling edge and samples on the next falling edge, so each check falls exactly in the cycle that its count of registers gives.

// File: rtl/iso_in_pkg.sv
package iso_in_pkg;

  localparam int BYTE_W = 8;
  localparam int REG_AW = 3;

  // register addresses
  localparam logic [REG_AW-1:0] RA_CTL   = 3'd0;
  localparam logic [REG_AW-1:0] RA_SIZE  = 3'd1;
  localparam logic [REG_AW-1:0] RA_XBASE = 3'd2;
  localparam logic [REG_AW-1:0] RA_YBASE = 3'd3;
  localparam logic [REG_AW-1:0] RA_XCNT  = 3'd4;
  localparam logic [REG_AW-1:0] RA_YCNT  = 3'd5;

  // control register bit positions
  localparam int CB_EN  = 0;
  localparam int CB_ISO = 1;
  localparam int CB_BPS = 2;
  localparam int CB_OVF = 7;

  // count byte: NACK flag on top, sample count below
  localparam int NACK_BIT = 7;
  localparam logic [BYTE_W-1:0] CNT_RESET = 8'h80;

  typedef enum logic [1:0] {
    SND_IDLE  = 2'd0,
    SND_SEND  = 2'd1,
    SND_CLOSE = 2'd2
  } snd_state_t;

  // bytes in a packet: samples times bytes-per-sample, capped at buffer size
  function automatic logic [BYTE_W-1:0] calc_pkt_bytes(
    input logic [6:0]        samples,
    input logic [1:0]        bps_code,
    input logic [BYTE_W-1:0] size
  );
    logic [8:0] prod;
    prod = {2'b00, samples} * ({7'd0, bps_code} + 9'd1);
    if (prod > {1'b0, size}) return size;
    return prod[BYTE_W-1:0];
  endfunction

endpackage

// File: rtl/iso_ep_cfg.sv
module iso_ep_cfg
  import iso_in_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [REG_AW-1:0] cfg_addr,
  input  logic [BYTE_W-1:0] cfg_wdata,
  output logic [BYTE_W-1:0] cfg_rdata,
  input  logic              ovf_hit,
  input  logic [BYTE_W-1:0] cnt_x,
  input  logic [BYTE_W-1:0] cnt_y,
  output logic              ep_on,
  output logic              en_rise,
  output logic [1:0]        bps_code,
  output logic [BYTE_W-1:0] buf_size,
  output logic [BYTE_W-1:0] base_x,
  output logic [BYTE_W-1:0] base_y,
  output logic              ovf_flag
);

  logic en_q, iso_q, ovf_q;
  logic [1:0] bps_q;
  logic [BYTE_W-1:0] size_q, xb_q, yb_q;
  logic wr_ctl;

  assign wr_ctl  = cfg_we && (cfg_addr == RA_CTL);
  assign ep_on   = en_q && iso_q;
  assign en_rise = wr_ctl && cfg_wdata[CB_EN] && cfg_wdata[CB_ISO] && !ep_on;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      iso_q  <= 1'b0;
      bps_q  <= 2'd0;
      ovf_q  <= 1'b0;
      size_q <= '0;
      xb_q   <= '0;
      yb_q   <= '0;
    end else begin
      if (wr_ctl) begin
        en_q  <= cfg_wdata[CB_EN];
        iso_q <= cfg_wdata[CB_ISO];
        bps_q <= cfg_wdata[CB_BPS +: 2];
      end
      // overflow: set wins, a zero written to its bit clears
      if (ovf_hit) ovf_q <= 1'b1;
      else if (wr_ctl && !cfg_wdata[CB_OVF]) ovf_q <= 1'b0;
      if (cfg_we && cfg_addr == RA_SIZE)  size_q <= cfg_wdata;
      if (cfg_we && cfg_addr == RA_XBASE) xb_q   <= cfg_wdata;
      if (cfg_we && cfg_addr == RA_YBASE) yb_q   <= cfg_wdata;
    end
  end

  always_comb begin
    unique case (cfg_addr)
      RA_CTL:   cfg_rdata = {ovf_q, 3'b000, bps_q, iso_q, en_q};
      RA_SIZE:  cfg_rdata = size_q;
      RA_XBASE: cfg_rdata = xb_q;
      RA_YBASE: cfg_rdata = yb_q;
      RA_XCNT:  cfg_rdata = cnt_x;
      RA_YCNT:  cfg_rdata = cnt_y;
      default:  cfg_rdata = '0;
    endcase
  end

  assign bps_code = bps_q;
  assign buf_size = size_q;
  assign base_x   = xb_q;
  assign base_y   = yb_q;
  assign ovf_flag = ovf_q;

endmodule

// File: rtl/iso_buf_store.sv
module iso_buf_store
  import iso_in_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              prod_we,
  input  logic              prod_cnt,
  input  logic              prod_buf,
  input  logic [BYTE_W-1:0] prod_off,
  input  logic [BYTE_W-1:0] prod_wdata,
  input  logic [BYTE_W-1:0] buf_size,
  input  logic [BYTE_W-1:0] base_x,
  input  logic [BYTE_W-1:0] base_y,
  input  logic              arm,
  input  logic              close_x,
  input  logic              close_y,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [BYTE_W-1:0] rd_data,
  output logic [BYTE_W-1:0] cnt_x,
  output logic [BYTE_W-1:0] cnt_y,
  output logic              ovf_hit
);

  localparam int MEM_BYTES = 1 << ADDR_W;

  logic [BYTE_W-1:0] mem [MEM_BYTES];
  logic [BYTE_W-1:0] sel_base;
  logic [ADDR_W-1:0] wr_addr;
  logic              in_range, data_we;
  logic [1:0]        close_v;

  assign sel_base = prod_buf ? base_y : base_x;
  assign wr_addr  = ADDR_W'(sel_base + prod_off);
  assign in_range = prod_off < buf_size;
  assign data_we  = prod_we && !prod_cnt && in_range;
  assign ovf_hit  = prod_we && !prod_cnt && !in_range;
  assign close_v  = {close_y, close_x};

  always_ff @(posedge clk) begin
    if (data_we) mem[wr_addr] <= prod_wdata;
  end

  assign rd_data = mem[rd_addr];

  // one count byte per buffer; the sender's hand-back wins over the producer
  for (genvar b = 0; b < 2; b++) begin : g_cnt
    logic [BYTE_W-1:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= CNT_RESET;
      else if (arm || close_v[b]) q[NACK_BIT] <= 1'b1;
      else if (prod_we && prod_cnt && (prod_buf == 1'(b))) q <= prod_wdata;
    end
  end

  assign cnt_x = g_cnt[0].q;
  assign cnt_y = g_cnt[1].q;

endmodule

// File: rtl/iso_in_sender.sv
module iso_in_sender
  import iso_in_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ep_on,
  input  logic              arm,
  input  logic              tok_in,
  input  logic [BYTE_W-1:0] cnt_x,
  input  logic [BYTE_W-1:0] cnt_y,
  input  logic [1:0]        bps_code,
  input  logic [BYTE_W-1:0] buf_size,
  input  logic [BYTE_W-1:0] base_x,
  input  logic [BYTE_W-1:0] base_y,
  input  logic              tx_ready,
  input  logic [BYTE_W-1:0] rd_data,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              hs_valid,
  output logic              hs_null,
  output logic [BYTE_W-1:0] hs_len,
  output logic              tx_valid,
  output logic [BYTE_W-1:0] tx_data,
  output logic              tx_last,
  output logic              act_buf,
  output logic              busy,
  output logic              xfer_done,
  output logic              close_x,
  output logic              close_y
);

  snd_state_t        st;
  logic              act_q;
  logic [BYTE_W-1:0] len_q, idx_q, base_q;
  logic [BYTE_W-1:0] cur_cnt, cur_base, new_len;
  logic              cur_nack, take, beat, at_last;

  assign cur_cnt  = act_q ? cnt_y : cnt_x;
  assign cur_base = act_q ? base_y : base_x;
  assign cur_nack = cur_cnt[NACK_BIT];
  assign new_len  = cur_nack ? '0 : calc_pkt_bytes(cur_cnt[6:0], bps_code, buf_size);
  assign take     = ep_on && (st == SND_IDLE) && tok_in;

  assign tx_valid  = ep_on && (st == SND_SEND);
  assign at_last   = idx_q == (len_q - 8'd1);
  assign tx_last   = tx_valid && at_last;
  assign tx_data   = rd_data;
  assign beat      = tx_valid && tx_ready;
  assign rd_addr   = ADDR_W'(base_q + idx_q);
  assign xfer_done = ep_on && ((st == SND_CLOSE) || (beat && at_last));
  assign close_x   = xfer_done && !act_q;
  assign close_y   = xfer_done && act_q;
  assign act_buf   = act_q;
  assign busy      = st != SND_IDLE;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= SND_IDLE;
      act_q    <= 1'b0;
      len_q    <= '0;
      idx_q    <= '0;
      base_q   <= '0;
      hs_valid <= 1'b0;
      hs_null  <= 1'b0;
      hs_len   <= '0;
    end else begin
      hs_valid <= 1'b0;
      if (!ep_on) begin
        st <= SND_IDLE;
        if (arm) act_q <= 1'b0;
      end else begin
        unique case (st)
          SND_IDLE: if (take) begin
            hs_valid <= 1'b1;
            hs_null  <= cur_nack;
            hs_len   <= new_len;
            len_q    <= new_len;
            base_q   <= cur_base;
            idx_q    <= '0;
            st       <= (new_len == '0) ? SND_CLOSE : SND_SEND;
          end
          SND_SEND: if (beat) begin
            idx_q <= idx_q + 8'd1;
            if (at_last) begin
              st    <= SND_IDLE;
              act_q <= !act_q;
            end
          end
          SND_CLOSE: begin
            st    <= SND_IDLE;
            act_q <= !act_q;
          end
          default: st <= SND_IDLE;
        endcase
      end
    end
  end

endmodule

// File: rtl/iso_in_dbuf.sv
module iso_in_dbuf
  import iso_in_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_we,
  input  logic [2:0]  cfg_addr,
  input  logic [7:0]  cfg_wdata,
  output logic [7:0]  cfg_rdata,
  input  logic        prod_we,
  input  logic        prod_cnt,
  input  logic        prod_buf,
  input  logic [7:0]  prod_off,
  input  logic [7:0]  prod_wdata,
  input  logic        tok_in,
  output logic        hs_valid,
  output logic        hs_null,
  output logic [7:0]  hs_len,
  output logic        tx_valid,
  input  logic        tx_ready,
  output logic [7:0]  tx_data,
  output logic        tx_last,
  output logic        act_buf,
  output logic        busy
);

  logic              ep_on, en_rise, ovf_hit, ovf_flag;
  logic [1:0]        bps_code;
  logic [BYTE_W-1:0] buf_size, base_x, base_y, cnt_x, cnt_y, rd_data;
  logic [ADDR_W-1:0] rd_addr;
  logic              xfer_done, close_x, close_y;
  logic              nack_x, nack_y;

  assign nack_x = cnt_x[NACK_BIT];
  assign nack_y = cnt_y[NACK_BIT];

  iso_ep_cfg u_cfg (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_we   (cfg_we),
    .cfg_addr (cfg_addr),
    .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata),
    .ovf_hit  (ovf_hit),
    .cnt_x    (cnt_x),
    .cnt_y    (cnt_y),
    .ep_on    (ep_on),
    .en_rise  (en_rise),
    .bps_code (bps_code),
    .buf_size (buf_size),
    .base_x   (base_x),
    .base_y   (base_y),
    .ovf_flag (ovf_flag)
  );

  iso_buf_store #(.ADDR_W(ADDR_W)) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .prod_we   (prod_we),
    .prod_cnt  (prod_cnt),
    .prod_buf  (prod_buf),
    .prod_off  (prod_off),
    .prod_wdata(prod_wdata),
    .buf_size  (buf_size),
    .base_x    (base_x),
    .base_y    (base_y),
    .arm       (en_rise),
    .close_x   (close_x),
    .close_y   (close_y),
    .rd_addr   (rd_addr),
    .rd_data   (rd_data),
    .cnt_x     (cnt_x),
    .cnt_y     (cnt_y),
    .ovf_hit   (ovf_hit)
  );

  iso_in_sender #(.ADDR_W(ADDR_W)) u_snd (
    .clk      (clk),
    .rst_n    (rst_n),
    .ep_on    (ep_on),
    .arm      (en_rise),
    .tok_in   (tok_in),
    .cnt_x    (cnt_x),
    .cnt_y    (cnt_y),
    .bps_code (bps_code),
    .buf_size (buf_size),
    .base_x   (base_x),
    .base_y   (base_y),
    .tx_ready (tx_ready),
    .rd_data  (rd_data),
    .rd_addr  (rd_addr),
    .hs_valid (hs_valid),
    .hs_null  (hs_null),
    .hs_len   (hs_len),
    .tx_valid (tx_valid),
    .tx_data  (tx_data),
    .tx_last  (tx_last),
    .act_buf  (act_buf),
    .busy     (busy),
    .xfer_done(xfer_done),
    .close_x  (close_x),
    .close_y  (close_y)
  );

endmodule

// File: rtl/iso_in_dbuf_chk.sv
module iso_in_dbuf_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       tok_in,
  input logic       ep_on,
  input logic       en_rise,
  input logic       hs_valid,
  input logic       hs_null,
  input logic       tx_valid,
  input logic       tx_ready,
  input logic       tx_last,
  input logic       act_buf,
  input logic       busy,
  input logic       xfer_done,
  input logic       nack_x,
  input logic       nack_y,
  input logic       ovf_flag,
  input logic       cfg_we,
  input logic [2:0] cfg_addr,
  input logic [7:0] cfg_wdata
);

  logic ovf_clear;
  assign ovf_clear = cfg_we && (cfg_addr == 3'd0) && !cfg_wdata[7];

  a_r2_hs_single: assert property (@(posedge clk) disable iff (!rst_n)
    hs_valid |=> !hs_valid);

  a_r3_hold_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready && ep_on) |=> (tx_valid && $stable(tx_last)));

  a_r4_nack_x_back: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_done && !act_buf) |=> nack_x);

  a_r4_nack_y_back: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_done && act_buf) |=> nack_y);

  a_r5_null_no_data: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_valid && hs_null) |-> !tx_valid);

  a_r6_toggle: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |=> (act_buf != $past(act_buf)));

  a_r7_arm: assert property (@(posedge clk) disable iff (!rst_n)
    en_rise |=> (!act_buf && nack_x && nack_y));

  a_r8_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!ep_on && tok_in) |=> !hs_valid);

  a_r9_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_flag && !ovf_clear) |=> ovf_flag);

  a_r11_busy_tok: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && tok_in) |=> !hs_valid);

endmodule

bind iso_in_dbuf iso_in_dbuf_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .tok_in   (tok_in),
  .ep_on    (ep_on),
  .en_rise  (en_rise),
  .hs_valid (hs_valid),
  .hs_null  (hs_null),
  .tx_valid (tx_valid),
  .tx_ready (tx_ready),
  .tx_last  (tx_last),
  .act_buf  (act_buf),
  .busy     (busy),
  .xfer_done(xfer_done),
  .nack_x   (nack_x),
  .nack_y   (nack_y),
  .ovf_flag (ovf_flag),
  .cfg_we   (cfg_we),
  .cfg_addr (cfg_addr),
  .cfg_wdata(cfg_wdata)
);

// File: tb/iso_in_dbuf_test.sv
module iso_in_dbuf_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_we = 1'b0;
  logic [2:0] cfg_addr = 3'd0;
  logic [7:0] cfg_wdata = 8'd0;
  logic [7:0] cfg_rdata;
  logic       prod_we = 1'b0, prod_cnt = 1'b0, prod_buf = 1'b0;
  logic [7:0] prod_off = 8'd0, prod_wdata = 8'd0;
  logic       tok_in = 1'b0;
  logic       hs_valid, hs_null, tx_valid, tx_last, act_buf, busy;
  logic [7:0] hs_len, tx_data;
  logic       tx_ready = 1'b1;

  int runs = 0;
  int fails = 0;

  // bench-side model of memory and layout
  logic [7:0] shadow [64];
  int size_sh = 0, xb_sh = 0, yb_sh = 0;

  always #10 clk = ~clk;

  iso_in_dbuf uut (.*);

  task automatic chk(input string req, input string what, input int act, input int exp);
    runs++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", runs, fails);
  endtask

  task automatic cfg_wr(input logic [2:0] a, input logic [7:0] d);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    if (a == 3'd1) size_sh = d;
    if (a == 3'd2) xb_sh = d;
    if (a == 3'd3) yb_sh = d;
  endtask

  task automatic cfg_rd(input logic [2:0] a, output logic [7:0] d);
    cfg_addr = a;
    #1;
    d = cfg_rdata;
  endtask

  task automatic prod_wr(input logic c, input logic b, input int off, input logic [7:0] d);
    prod_we = 1'b1; prod_cnt = c; prod_buf = b; prod_off = 8'(off); prod_wdata = d;
    @(negedge clk);
    prod_we = 1'b0;
    if (!c && off < size_sh) shadow[((b ? yb_sh : xb_sh) + off) % 64] = d;
  endtask

  task automatic token();
    tok_in = 1'b1;
    @(negedge clk);
    tok_in = 1'b0;
  endtask

  task automatic expect_stream(input string req, input int len, input int base);
    for (int i = 0; i < len; i++) begin
      chk(req, "tx_valid", int'(tx_valid), 1);
      chk(req, "tx_data", int'(tx_data), int'(shadow[(base + i) % 64]));
      chk(req, "tx_last", int'(tx_last), (i == len - 1) ? 1 : 0);
      @(negedge clk);
    end
    chk(req, "tx_valid after packet", int'(tx_valid), 0);
  endtask

  // R1
  task automatic t_reset();
    logic [7:0] d;
    chk("R1", "hs_valid", int'(hs_valid), 0);
    chk("R1", "tx_valid", int'(tx_valid), 0);
    chk("R1", "busy", int'(busy), 0);
    chk("R1", "act_buf", int'(act_buf), 0);
    cfg_rd(3'd0, d); chk("R1", "ctl", int'(d), 8'h00);
    cfg_rd(3'd4, d); chk("R1", "x count", int'(d), 8'h80);
    cfg_rd(3'd5, d); chk("R1", "y count", int'(d), 8'h80);
  endtask

  // R2 R3 R4 R6
  task automatic t_basic();
    logic [7:0] d;
    for (int i = 0; i < 8; i++) prod_wr(1'b0, 1'b0, i, 8'(8'h10 + i));
    prod_wr(1'b1, 1'b0, 0, 8'h04);
    token();
    chk("R2", "hs_valid", int'(hs_valid), 1);
    chk("R2", "hs_null", int'(hs_null), 0);
    chk("R2", "hs_len", int'(hs_len), 4);
    expect_stream("R3", 4, xb_sh);
    chk("R2", "hs_valid one cycle", int'(hs_valid), 0);
    chk("R6", "act after X", int'(act_buf), 1);
    cfg_rd(3'd4, d); chk("R4", "x nack back", int'(d[7]), 1);
  endtask

  // R5 R6
  task automatic t_null();
    token();
    chk("R5", "hs_valid", int'(hs_valid), 1);
    chk("R5", "hs_null", int'(hs_null), 1);
    chk("R5", "hs_len", int'(hs_len), 0);
    chk("R5", "tx_valid", int'(tx_valid), 0);
    @(negedge clk);
    chk("R5", "tx_valid after", int'(tx_valid), 0);
    chk("R6", "act after null", int'(act_buf), 0);
  endtask

  // R10
  task automatic t_bps();
    cfg_wr(3'd0, 8'h0B);
    prod_wr(1'b1, 1'b0, 0, 8'h02);
    token();
    chk("R10", "hs_len 2x3", int'(hs_len), 6);
    expect_stream("R10", 6, xb_sh);
    for (int i = 0; i < 8; i++) prod_wr(1'b0, 1'b1, i, 8'(8'hC0 + i));
    prod_wr(1'b1, 1'b1, 0, 8'h03);
    token();
    chk("R10", "hs_len saturated", int'(hs_len), 8);
    expect_stream("R10", 8, yb_sh);
    chk("R6", "act after Y", int'(act_buf), 0);
  endtask

  // R3 R11
  task automatic t_stall_busy();
    cfg_wr(3'd0, 8'h03);
    prod_wr(1'b1, 1'b0, 0, 8'h03);
    tx_ready = 1'b0;
    token();
    chk("R3", "stalled valid", int'(tx_valid), 1);
    chk("R3", "stalled byte0", int'(tx_data), int'(shadow[xb_sh]));
    tok_in = 1'b1;
    @(negedge clk);
    tok_in = 1'b0;
    chk("R11", "busy token ignored", int'(hs_valid), 0);
    chk("R3", "held byte0", int'(tx_data), int'(shadow[xb_sh]));
    chk("R3", "held not last", int'(tx_last), 0);
    tx_ready = 1'b1;
    expect_stream("R3", 3, xb_sh);
    chk("R6", "act after stall", int'(act_buf), 1);
  endtask

  // R8
  task automatic t_disabled();
    cfg_wr(3'd0, 8'h02);
    token();
    chk("R8", "iso only: hs_valid", int'(hs_valid), 0);
    chk("R8", "iso only: act", int'(act_buf), 1);
    cfg_wr(3'd0, 8'h01);
    prod_wr(1'b1, 1'b1, 0, 8'h02);
    token();
    chk("R8", "en only: hs_valid", int'(hs_valid), 0);
    chk("R8", "en only: tx_valid", int'(tx_valid), 0);
    @(negedge clk);
    chk("R8", "en only: act", int'(act_buf), 1);
  endtask

  // R7
  task automatic t_arm();
    logic [7:0] d;
    cfg_rd(3'd5, d); chk("R7", "y count before", int'(d), 8'h02);
    cfg_wr(3'd0, 8'h03);
    chk("R7", "act reset", int'(act_buf), 0);
    cfg_rd(3'd4, d); chk("R7", "x nack", int'(d[7]), 1);
    cfg_rd(3'd5, d); chk("R7", "y nack", int'(d[7]), 1);
  endtask

  // R9
  task automatic t_overflow();
    logic [7:0] d;
    cfg_wr(3'd1, 8'd16);
    prod_wr(1'b0, 1'b0, 8, 8'hAA);
    cfg_rd(3'd0, d); chk("R9", "in range no ovf", int'(d[7]), 0);
    cfg_wr(3'd1, 8'd8);
    prod_wr(1'b0, 1'b0, 8, 8'h55);
    cfg_rd(3'd0, d); chk("R9", "ovf set", int'(d[7]), 1);
    cfg_wr(3'd0, 8'h83);
    cfg_rd(3'd0, d); chk("R9", "ovf sticky", int'(d[7]), 1);
    cfg_wr(3'd0, 8'h03);
    cfg_rd(3'd0, d); chk("R9", "ovf cleared", int'(d[7]), 0);
    cfg_wr(3'd1, 8'd16);
    prod_wr(1'b1, 1'b0, 0, 8'h09);
    token();
    chk("R9", "hs_len", int'(hs_len), 9);
    expect_stream("R9", 9, xb_sh);
    chk("R9", "dropped write kept 0xAA", int'(shadow[(xb_sh + 8) % 64]), 8'hAA);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++) shadow[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    cfg_wr(3'd1, 8'd8);
    cfg_wr(3'd2, 8'd0);
    cfg_wr(3'd3, 8'd16);
    cfg_wr(3'd0, 8'h03);
    t_basic();
    t_null();
    t_bps();
    t_stall_busy();
    t_disabled();
    t_arm();
    t_overflow();
    summary();
    $finish;
  end

endmodule